// File: doc/BRIEF.md
# Pattern Trigger Sequencer

This block watches the words coming out of a logic analyzer's sampling stage and decides when the capture logic should be told to trigger. Two pattern recognisers each hold one 3-bit condition per channel: a level, an edge between two samples, or don't care. Their results can be used alone, joined by AND, or joined by OR. A mode can instead select a single external trigger input.

The final condition is turned into an event in one of two ways. The event can be a change of the condition, either into true or into false. It can also be the end of a run of samples whose length lies between a programmed minimum and maximum. A pass counter skips a programmed number of events before the trigger fires. A small state machine arms the block, counts the skipped events, and then emits a single registered pulse. It then stays in its triggered state until software arms it again.

Only samples qualified by `smp_valid` count. The previous valid sample, the previous condition value and the run length advance on every valid sample, whatever the sequencer state.

Top module: `pattern_trigger`

## Requirements
- R1: The condition for channel i is read from bits [3i+2:3i] of a recogniser's condition bus. Code 0 means don't care, 1 means low, 2 means high, 3 means rising, 4 means falling and 5 means either edge. Codes 6 and 7 behave as don't care. A recogniser matches when every one of its channels matches.
- R2: The edge codes compare the current valid sample with the previous valid sample of the same channel. On the first valid sample after reset they are false. A cycle with `smp_valid` low neither updates the history nor produces an event.
- R3: `cfg_comb` selects the final condition: 0 uses recogniser A, 1 uses A AND B, 2 uses A OR B, and 3 uses `ext_trig_in` sampled with the word.
- R4: With `cfg_dur_en` low, an event is a change of the final condition between two consecutive valid samples. When `cfg_fall` is 0 the change must be false to true; when it is 1 the change must be true to false. The stored condition starts out false after reset.
- R5: When armed with `cfg_pass` = N (0 to 1023), the block skips the first N events and fires on event N+1.
- R6: With `cfg_dur_en` high, the block tracks a level equal to the final condition XOR `cfg_fall`. It counts the consecutive valid samples on which this level is true. An event occurs on the first valid sample where the level is false, provided the run was nonzero and lay between `cfg_dur_min` and `cfg_dur_max`, both limits included.
- R7: `trig_out` is high for exactly one clock, in the cycle after the clock edge that took the firing sample.
- R8: Once the block has fired, it gives no further pulse until `arm` is applied again. After reset it never fires without `arm`. If `arm` coincides with an event, the block restarts and the event is not counted.
- R9: Synchronous reset clears `trig_out` and returns the sequencer to its idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart the sequence; latches the pass count |
| smp_valid | input | 1 | Qualifies `smp_data` and `ext_trig_in` as a sample |
| smp_data | input | NCH | Sampled channel word |
| ext_trig_in | input | 1 | External trigger level, usable as the condition |
| cfg_cond_a | input | 3*NCH | Per-channel condition codes, recogniser A |
| cfg_cond_b | input | 3*NCH | Per-channel condition codes, recogniser B |
| cfg_comb | input | 2 | Final condition selection |
| cfg_fall | input | 1 | Event polarity; in duration mode, inverts the timed level |
| cfg_pass | input | PASS_W | Number of events to skip |
| cfg_dur_en | input | 1 | Selects duration qualification |
| cfg_dur_min | input | DUR_W | Shortest accepted run, in samples |
| cfg_dur_max | input | DUR_W | Longest accepted run, in samples |
| trig_out | output | 1 | One-clock trigger pulse |

## Verification
A vector table drives a rising-edge-and-high pattern through toggling words, repeated words and invalid cycles. It separates a real edge from a level that merely persists, and shows that samples with `smp_valid` low leave the history untouched. Directed patterns then go through the remaining codes, including the first-sample rule for edge codes. They compare AND with OR on a word where only one recogniser matches, and try the external-input mode. Pass counts of 3 and 1023 show where the firing event falls. Duration runs one sample short of, exactly at, and one sample beyond each limit show that both bounds are inclusive.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

    typedef enum logic [2:0] {
        CC_DC   = 3'd0,
        CC_LO   = 3'd1,
        CC_HI   = 3'd2,
        CC_RISE = 3'd3,
        CC_FALL = 3'd4,
        CC_ANY  = 3'd5
    } cond_e;

    typedef enum logic [1:0] {
        CB_A   = 2'd0,
        CB_AND = 2'd1,
        CB_OR  = 2'd2,
        CB_EXT = 2'd3
    } comb_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_COUNT = 2'd2,
        SQ_TRIG  = 2'd3
    } seq_e;

    localparam int CODE_W = 3;

    // one channel against its condition; codes outside the enum are don't care
    function automatic logic chan_hit(input logic [CODE_W-1:0] code,
                                      input logic cur, input logic prv,
                                      input logic prv_ok);
        case (code)
            CC_LO:   return !cur;
            CC_HI:   return cur;
            CC_RISE: return prv_ok && cur && !prv;
            CC_FALL: return prv_ok && !cur && prv;
            CC_ANY:  return prv_ok && (cur ^ prv);
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/ptrig_recog.sv
module ptrig_recog #(
    parameter int NCH = 18
) (
    input  logic [ptrig_pkg::CODE_W*NCH-1:0] codes,
    input  logic [NCH-1:0]                   cur,
    input  logic [NCH-1:0]                   prv,
    input  logic                             prv_ok,
    output logic                             match
);
    localparam int CW = ptrig_pkg::CODE_W;

    logic [NCH-1:0] hit;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign hit[i] = ptrig_pkg::chan_hit(codes[CW*i +: CW], cur[i], prv[i], prv_ok);
    end

    assign match = &hit;

endmodule

// File: rtl/ptrig_qual.sv
module ptrig_qual #(
    parameter int NCH   = 18,
    parameter int DUR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [NCH-1:0]   smp_data,
    input  logic             cond,
    input  logic             cfg_fall,
    input  logic             cfg_dur_en,
    input  logic [DUR_W-1:0] cfg_dur_min,
    input  logic [DUR_W-1:0] cfg_dur_max,
    output logic [NCH-1:0]   prv_data,
    output logic             prv_ok,
    output logic             evt
);
    localparam logic [DUR_W-1:0] RUN_SAT = '1;

    logic             cond_q;
    logic [DUR_W-1:0] run;
    logic             level;
    logic             edge_evt;
    logic             dur_evt;

    assign level = cond ^ cfg_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            prv_data <= '0;
            prv_ok   <= 1'b0;
            cond_q   <= 1'b0;
            run      <= '0;
        end else if (smp_valid) begin
            prv_data <= smp_data;
            prv_ok   <= 1'b1;
            cond_q   <= cond;
            if (!level)
                run <= '0;
            else if (run != RUN_SAT)
                run <= run + 1'b1;
        end
    end

    always_comb begin
        edge_evt = cfg_fall ? (!cond && cond_q) : (cond && !cond_q);
        dur_evt  = !level && (run != '0) && (run >= cfg_dur_min) && (run <= cfg_dur_max);
        evt      = smp_valid && (cfg_dur_en ? dur_evt : edge_evt);
    end

endmodule

// File: rtl/ptrig_fsm.sv
module ptrig_fsm #(
    parameter int PASS_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              evt,
    input  logic [PASS_W-1:0] cfg_pass,
    output ptrig_pkg::seq_e   state,
    output logic              trig_out
);
    import ptrig_pkg::*;

    logic [PASS_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            remain   <= '0;
            trig_out <= 1'b0;
        end else begin
            trig_out <= 1'b0;
            if (arm) begin
                remain <= cfg_pass;
                state  <= (cfg_pass == '0) ? SQ_ARMED : SQ_COUNT;
            end else if (evt) begin
                case (state)
                    SQ_COUNT: begin
                        remain <= remain - 1'b1;
                        if (remain == PASS_W'(1))
                            state <= SQ_ARMED;
                    end
                    SQ_ARMED: begin
                        state    <= SQ_TRIG;
                        trig_out <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/pattern_trigger.sv
module pattern_trigger #(
    parameter int NCH    = 18,
    parameter int PASS_W = 10,
    parameter int DUR_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              arm,
    input  logic                              smp_valid,
    input  logic [NCH-1:0]                    smp_data,
    input  logic                              ext_trig_in,
    input  logic [ptrig_pkg::CODE_W*NCH-1:0]  cfg_cond_a,
    input  logic [ptrig_pkg::CODE_W*NCH-1:0]  cfg_cond_b,
    input  logic [1:0]                        cfg_comb,
    input  logic                              cfg_fall,
    input  logic [PASS_W-1:0]                 cfg_pass,
    input  logic                              cfg_dur_en,
    input  logic [DUR_W-1:0]                  cfg_dur_min,
    input  logic [DUR_W-1:0]                  cfg_dur_max,
    output logic                              trig_out
);
    import ptrig_pkg::*;

    localparam int NREC = 2;
    localparam int CBW  = CODE_W * NCH;

    logic [CBW-1:0]  rec_codes [NREC];
    logic [NREC-1:0] rec_match;
    logic [NCH-1:0]  prv_data;
    logic            prv_ok;
    logic            cond;
    logic            evt;
    seq_e            fsm_state;

    assign rec_codes[0] = cfg_cond_a;
    assign rec_codes[1] = cfg_cond_b;

    for (genvar r = 0; r < NREC; r++) begin : g_rec
        ptrig_recog #(.NCH(NCH)) u_rec (
            .codes  (rec_codes[r]),
            .cur    (smp_data),
            .prv    (prv_data),
            .prv_ok (prv_ok),
            .match  (rec_match[r])
        );
    end

    always_comb begin
        case (comb_e'(cfg_comb))
            CB_AND:  cond = rec_match[0] && rec_match[1];
            CB_OR:   cond = rec_match[0] || rec_match[1];
            CB_EXT:  cond = ext_trig_in;
            default: cond = rec_match[0];
        endcase
    end

    ptrig_qual #(.NCH(NCH), .DUR_W(DUR_W)) u_qual (
        .clk         (clk),
        .rst         (rst),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .cond        (cond),
        .cfg_fall    (cfg_fall),
        .cfg_dur_en  (cfg_dur_en),
        .cfg_dur_min (cfg_dur_min),
        .cfg_dur_max (cfg_dur_max),
        .prv_data    (prv_data),
        .prv_ok      (prv_ok),
        .evt         (evt)
    );

    ptrig_fsm #(.PASS_W(PASS_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .arm      (arm),
        .evt      (evt),
        .cfg_pass (cfg_pass),
        .state    (fsm_state),
        .trig_out (trig_out)
    );

endmodule

// File: rtl/pattern_trigger_chk.sv
module pattern_trigger_chk (
    input logic            clk,
    input logic            rst,
    input logic            arm,
    input logic            smp_valid,
    input logic            trig_out,
    input ptrig_pkg::seq_e seq_state
);
    import ptrig_pkg::*;

    // R7: one-clock pulse
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out);

    // R2: a pulse always follows a valid sample
    p_from_valid_r2: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(smp_valid));

    // R5: the firing event is taken only after all skips are done
    p_fire_from_armed_r5: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> $past(seq_state == SQ_ARMED));

    // R8: idle never fires
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SQ_IDLE) |=> !trig_out);

    // R8: triggered holds until re-armed
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == SQ_TRIG && !arm) |=> (seq_state == SQ_TRIG && !trig_out));

    // R8: arm takes precedence over a coincident event
    p_arm_wins_r8: assert property (@(posedge clk) disable iff (rst)
        arm |=> !trig_out);

    // R9: reset clears the pulse and the sequencer
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!trig_out && seq_state == SQ_IDLE));

endmodule

bind pattern_trigger pattern_trigger_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .smp_valid (smp_valid),
    .trig_out  (trig_out),
    .seq_state (fsm_state)
);

// File: tb/pattern_trigger_tb_top.sv
module pattern_trigger_tb_top;

    localparam int NCH    = 18;
    localparam int PASS_W = 10;
    localparam int DUR_W  = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               arm = 1'b0;
    logic               smp_valid = 1'b0;
    logic [NCH-1:0]     smp_data = '0;
    logic               ext_trig_in = 1'b0;
    logic [3*NCH-1:0]   cfg_cond_a = '0;
    logic [3*NCH-1:0]   cfg_cond_b = '0;
    logic [1:0]         cfg_comb = 2'd0;
    logic               cfg_fall = 1'b0;
    logic [PASS_W-1:0]  cfg_pass = '0;
    logic               cfg_dur_en = 1'b0;
    logic [DUR_W-1:0]   cfg_dur_min = '0;
    logic [DUR_W-1:0]   cfg_dur_max = '0;
    logic               trig_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pattern_trigger #(.NCH(NCH), .PASS_W(PASS_W), .DUR_W(DUR_W)) dut_i (
        .clk, .rst, .arm, .smp_valid, .smp_data, .ext_trig_in,
        .cfg_cond_a, .cfg_cond_b, .cfg_comb, .cfg_fall, .cfg_pass,
        .cfg_dur_en, .cfg_dur_min, .cfg_dur_max, .trig_out
    );

    // table: [4]=arm [3]=valid [2:1]=ch1,ch0 [0]=expected trig_out
    // recogniser A: ch0 rising (code 3), ch1 high (code 2)
    localparam logic [4:0] VT [0:13] = '{
        5'b10000, 5'b01000, 5'b01010, 5'b01100, 5'b01111,
        5'b01000, 5'b01110, 5'b10000, 5'b01100, 5'b01111,
        5'b10000, 5'b01100, 5'b00110, 5'b01111
    };

    task automatic step(input logic a, input logic v, input logic [NCH-1:0] d, input logic e);
        @(negedge clk);
        arm = a; smp_valid = v; smp_data = d; ext_trig_in = e;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic exp, input string req, input string what);
        n_chk++;
        if (trig_out !== exp) begin
            n_fail++;
            $display("FAIL %s %s: trig_out=%0b expected %0b", req, what, trig_out, exp);
        end
    endtask

    task automatic smp(input logic [NCH-1:0] d, input logic exp, input string req, input string what);
        step(1'b0, 1'b1, d, 1'b0);
        check(exp, req, what);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        step(1'b0, 1'b0, '0, 1'b0);
        step(1'b0, 1'b0, '0, 1'b0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic do_arm();
        step(1'b1, 1'b0, '0, 1'b0);
    endtask

    function automatic logic [3*NCH-1:0] code1(input int ch, input logic [2:0] c);
        logic [3*NCH-1:0] v = '0;
        v[3*ch +: 3] = c;
        return v;
    endfunction

    task automatic cfg_default();
        cfg_cond_a = '0; cfg_cond_b = '0; cfg_comb = 2'd0; cfg_fall = 1'b0;
        cfg_pass = '0; cfg_dur_en = 1'b0; cfg_dur_min = '0; cfg_dur_max = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: trig_out=%0b expected completion", trig_out);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // R9: reset state, and R8: idle never fires without arm
        cfg_default();
        cfg_cond_a = code1(0, 3'd3) | code1(1, 3'd2);
        step(1'b0, 1'b1, 18'h3, 1'b0);
        check(1'b0, "R9", "during reset");
        do_reset();
        check(1'b0, "R9", "after reset");
        smp(18'h0, 1'b0, "R8", "idle sample 00");
        smp(18'h3, 1'b0, "R8", "idle qualifying word");

        // table walk: R1 R2 R4 R7 R8
        do_reset();
        for (int i = 0; i < 14; i++) begin
            step(VT[i][4], VT[i][3], {16'h0, VT[i][2:1]}, 1'b0);
            check(VT[i][0], "R1/R2/R4/R7/R8", $sformatf("table row %0d", i));
        end

        // R8: arm coincident with an event wins
        do_reset(); do_arm();
        smp(18'h0, 1'b0, "R8", "arm-wins setup");
        step(1'b1, 1'b1, 18'h3, 1'b0);
        check(1'b0, "R8", "arm with event");
        smp(18'h3, 1'b0, "R8", "held level no event");
        smp(18'h2, 1'b0, "R8", "ch0 low");
        smp(18'h3, 1'b1, "R8", "fires after re-arm");

        // R4: fire on becoming false, ch2 low
        cfg_default(); cfg_cond_a = code1(2, 3'd1); cfg_fall = 1'b1;
        do_reset(); do_arm();
        smp(18'h0, 1'b0, "R4", "falling polarity cond true");
        smp(18'h4, 1'b1, "R4", "falling polarity cond false");

        // R1: either edge, with first-sample rule R2
        cfg_default(); cfg_cond_a = code1(5, 3'd5);
        do_reset(); do_arm();
        smp(18'h00, 1'b0, "R2", "first sample no edge");
        smp(18'h20, 1'b1, "R1", "either edge rising");
        do_reset(); do_arm();
        smp(18'h20, 1'b0, "R2", "first sample high no edge");
        smp(18'h00, 1'b1, "R1", "either edge falling");
        // R1: falling edge code
        cfg_default(); cfg_cond_a = code1(6, 3'd4);
        do_reset(); do_arm();
        smp(18'h40, 1'b0, "R1", "fall code high");
        smp(18'h40, 1'b0, "R1", "fall code steady");
        smp(18'h00, 1'b1, "R1", "fall code edge");
        // R1: code 7 is don't care
        cfg_default(); cfg_cond_a = code1(0, 3'd7) | code1(1, 3'd2);
        do_reset(); do_arm();
        smp(18'h2, 1'b1, "R1", "code 7 don't care");

        // R3: AND / OR / external
        cfg_default(); cfg_cond_a = code1(3, 3'd2); cfg_cond_b = code1(4, 3'd2);
        cfg_comb = 2'd1;
        do_reset(); do_arm();
        smp(18'h08, 1'b0, "R3", "AND only A");
        smp(18'h18, 1'b1, "R3", "AND both");
        cfg_comb = 2'd2;
        do_reset(); do_arm();
        smp(18'h10, 1'b1, "R3", "OR only B");
        cfg_comb = 2'd3;
        do_reset(); do_arm();
        step(1'b0, 1'b1, 18'h18, 1'b0); check(1'b0, "R3", "ext low, data ignored");
        step(1'b0, 1'b1, 18'h00, 1'b1); check(1'b1, "R3", "ext high");

        // R5: pass count 3
        cfg_default(); cfg_cond_a = code1(0, 3'd2); cfg_pass = 10'd3;
        do_reset(); do_arm();
        for (int k = 0; k < 4; k++) begin
            smp(18'h1, (k == 3), "R5", $sformatf("pass3 event %0d", k + 1));
            smp(18'h0, 1'b0, "R5", "pass3 low");
        end
        // R5: pass count 1023
        cfg_pass = 10'd1023;
        do_reset(); do_arm();
        begin
            int early = 0;
            for (int k = 0; k < 1023; k++) begin
                step(1'b0, 1'b1, 18'h1, 1'b0);
                if (trig_out) early++;
                step(1'b0, 1'b1, 18'h0, 1'b0);
                if (trig_out) early++;
            end
            n_chk++;
            if (early != 0) begin
                n_fail++;
                $display("FAIL R5 pass1023 early pulses: got %0d expected 0", early);
            end
        end
        smp(18'h1, 1'b1, "R5", "pass1023 event 1024");

        // R6: duration window 3..5
        cfg_default(); cfg_cond_a = code1(0, 3'd2); cfg_dur_en = 1'b1;
        cfg_dur_min = 16'd3; cfg_dur_max = 16'd5;
        do_reset(); do_arm();
        smp(18'h1, 1'b0, "R6", "run2 s1"); smp(18'h1, 1'b0, "R6", "run2 s2");
        smp(18'h0, 1'b0, "R6", "run2 below min");
        for (int k = 0; k < 3; k++) smp(18'h1, 1'b0, "R6", "run3 body");
        smp(18'h0, 1'b1, "R6", "run3 at min");
        do_arm();
        for (int k = 0; k < 6; k++) smp(18'h1, 1'b0, "R6", "run6 body");
        smp(18'h0, 1'b0, "R6", "run6 above max");
        for (int k = 0; k < 5; k++) smp(18'h1, 1'b0, "R6", "run5 body");
        smp(18'h0, 1'b1, "R6", "run5 at max");
        // R6: inverted level, window 2..2
        cfg_fall = 1'b1; cfg_dur_min = 16'd2; cfg_dur_max = 16'd2;
        do_reset(); do_arm();
        smp(18'h1, 1'b0, "R6", "inv s1"); smp(18'h0, 1'b0, "R6", "inv s2");
        smp(18'h0, 1'b0, "R6", "inv s3");
        smp(18'h1, 1'b1, "R6", "inverted run of 2");
        step(1'b0, 1'b0, '0, 1'b0);
        check(1'b0, "R7", "pulse lasts one clock");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule